// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner gathers a large set of level-sensitive interrupt sources and folds them, eight at a time, into one output line per group, so that an upstream interrupt controller sees a single request for each group instead of each source. Every raw source first passes through a two-flop synchroniser. The synchronised level is then ANDed with a per-source enable bit, and the eight results of a group are ORed onto that group's output line. The line stays high for as long as any enabled source of the group is held active.

Software reaches the block through a small word-wide register port. Four groups share one 32-bit register bank, with one byte lane per group: group g sits in lane g mod 4 of bank g / 4. The banks repeat every 0x10 bytes. Each bank has three registers. One sets enable bits when a 1 is written to them. One clears enable bits when a 1 is written to them. One reports status, meaning the sources that are both active and enabled. A source's global number is group*8 plus its bit index within the group. The default build has 20 groups, which makes 160 sources in five banks.

The register port is a plain request port and has no back-pressure: a request is taken in every cycle that `reg_en` is high. Read data comes back one cycle later, qualified by `rd_valid`.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `grp_irq` bit is low, and enable reads return 0.
- R2: A write to bank offset 0x0 sets each enable bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R3: A write to bank offset 0x4 clears each enable bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A read of offset 0x0 or offset 0x4 returns the bank's current 32-bit enable mask.
- R5: A read of offset 0xC returns the synchronised source levels ANDed with the enables. Source bit i of group g appears at bit 8*(g mod 4)+i of bank g/4.
- R6: `grp_irq[g]` is the OR of group g's eight status bits. It stays high while an enabled source is held active and falls once no enabled source is active.
- R7: A change on `src_in` reaches `grp_irq` after exactly two rising clock edges. A change in the enables reaches `grp_irq` right after the edge that writes them.
- R8: Bank b occupies addresses b*0x10 to b*0x10+0xF. Group 19 lives in lane 3 (bits 31:24) of the bank at 0x40.
- R9: Writes to offset 0xC, to offset 0x8, or to a bank number past the last bank change nothing. Reads of offset 0x8 or of a missing bank return 0.
- R10: `rd_valid` is high in exactly the cycle after each read request, with `rd_data` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_en | input | 1 | Register request strobe |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 32 | Read data |
| src_in | input | NUM_GROUPS*8 | Raw level-sensitive interrupt sources |
| grp_irq | output | NUM_GROUPS | One combined interrupt line per group |

## Verification
The sources are first driven all high with no enables set. This shows that the enable mask alone gates the outputs. A single enabled source is then raised, held and dropped, which pins down the two-edge synchroniser latency and level behaviour that holds rather than pulses. Overlapping set and clear writes separate real write-one semantics from plain overwriting. Randomised source and enable patterns across all five banks, compared with both the status reads and `grp_irq`, catch errors in lane and bank mapping. Writes to the status offset, to the unused offset and to a missing bank are followed by read-back, which shows they are ignored.

// File: rtl/comb_pkg.sv
package comb_pkg;
  localparam int LANE_W         = 8;
  localparam int LANES_PER_BANK = 4;
  localparam int BANK_W_BITS    = LANE_W * LANES_PER_BANK;
  localparam int STRIDE_LSB     = 4;

  typedef enum logic [1:0] {
    SEL_SET  = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_NONE = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/comb_sync.sv
module comb_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/comb_bank.sv
module comb_bank
  import comb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_set,
  input  logic                   wr_clr,
  input  logic [BANK_W_BITS-1:0] wdata,
  input  logic [BANK_W_BITS-1:0] src_sync,
  output logic [BANK_W_BITS-1:0] en_q,
  output logic [BANK_W_BITS-1:0] status,
  output logic [LANES_PER_BANK-1:0] irq
);
  localparam int USED_BITS = LANES * LANE_W;
  localparam logic [BANK_W_BITS-1:0] LANE_MASK =
    (USED_BITS >= BANK_W_BITS) ? '1 : ((BANK_W_BITS'(1) << USED_BITS) - 1'b1);

  logic [BANK_W_BITS-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_set) en_d = en_d | wdata;
    if (wr_clr) en_d = en_d & ~wdata;
    en_d = en_d & LANE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  assign status = src_sync & en_q;

  genvar l;
  generate
    for (l = 0; l < LANES_PER_BANK; l++) begin : g_lane
      if (l < LANES) begin : g_used
        assign irq[l] = |status[l*LANE_W +: LANE_W];
      end else begin : g_unused
        assign irq[l] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import comb_pkg::*;
#(
  parameter int NUM_GROUPS  = 20,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_en,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic                         rd_valid,
  output logic [31:0]                  rd_data,
  input  logic [NUM_GROUPS*LANE_W-1:0] src_in,
  output logic [NUM_GROUPS-1:0]        grp_irq
);
  localparam int NUM_BANKS = (NUM_GROUPS + LANES_PER_BANK - 1) / LANES_PER_BANK;
  localparam int SRC_W     = NUM_GROUPS * LANE_W;
  localparam int PAD_W     = NUM_BANKS * BANK_W_BITS;
  localparam int BANK_W    = ADDR_W - STRIDE_LSB;

  logic [SRC_W-1:0]  src_sync;
  logic [PAD_W-1:0]  src_pad;
  logic [NUM_BANKS*LANES_PER_BANK-1:0] irq_all;
  logic [BANK_W_BITS-1:0] en_w   [NUM_BANKS];
  logic [BANK_W_BITS-1:0] stat_w [NUM_BANKS];

  logic [BANK_W-1:0] bank_idx;
  reg_sel_e          sel;
  logic              bank_ok;
  logic [31:0]       rd_d;
  logic [1:0]        unused_lsb;

  assign unused_lsb = reg_addr[1:0];
  assign bank_idx   = reg_addr[ADDR_W-1:STRIDE_LSB];
  assign sel        = reg_sel_e'(reg_addr[3:2]);
  assign bank_ok    = (int'(bank_idx) < NUM_BANKS);

  comb_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .d_in  (src_in),
    .d_out (src_sync)
  );

  generate
    if (PAD_W > SRC_W) begin : g_pad
      assign src_pad = {{(PAD_W-SRC_W){1'b0}}, src_sync};
    end else begin : g_nopad
      assign src_pad = src_sync;
    end
  endgenerate

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int LEFT  = NUM_GROUPS - b * LANES_PER_BANK;
      localparam int LANES = (LEFT > LANES_PER_BANK) ? LANES_PER_BANK : LEFT;
      logic hit;
      assign hit = reg_en && reg_we && (int'(bank_idx) == b);

      comb_bank #(.LANES(LANES)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_set   (hit && (sel == SEL_SET)),
        .wr_clr   (hit && (sel == SEL_CLR)),
        .wdata    (reg_wdata),
        .src_sync (src_pad[b*BANK_W_BITS +: BANK_W_BITS]),
        .en_q     (en_w[b]),
        .status   (stat_w[b]),
        .irq      (irq_all[b*LANES_PER_BANK +: LANES_PER_BANK])
      );
    end
  endgenerate

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_ok && (int'(bank_idx) == i)) begin
        unique case (sel)
          SEL_SET, SEL_CLR: rd_d = en_w[i];
          SEL_STAT:         rd_d = stat_w[i];
          default:          rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_en && !reg_we;
      if (reg_en && !reg_we) rd_data <= rd_d;
    end
  end

  assign grp_irq = irq_all[NUM_GROUPS-1:0];
endmodule

// File: rtl/irq_group_combiner_chk.sv
module irq_group_combiner_chk #(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_en,
  input logic                    reg_we,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic                    rd_valid,
  input logic [31:0]             rd_data,
  input logic [NUM_GROUPS*8-1:0] src_in,
  input logic [NUM_GROUPS-1:0]   grp_irq
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (grp_irq == '0)); // R1

  AST_NO_SRC_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (($past(src_in) == '0) && ($past(src_in, 2) == '0)) |-> (grp_irq == '0)); // R6

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (reg_en && !reg_we) |=> rd_valid); // R10

  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(reg_en && !reg_we)); // R10

  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_en && !reg_we && (reg_addr[3:2] == 2'b10)) |=> (rd_data == '0)); // R9
endmodule

bind irq_group_combiner irq_group_combiner_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .ADDR_W    (ADDR_W)
) chk_i (.*);

// File: tb/irq_group_combiner_tb_top.sv
module irq_group_combiner_tb_top;
  localparam int NG = 20;
  localparam int NB = 5;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_en = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NG*8-1:0] src_in = '0;
  logic [NG-1:0]   grp_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] m_en [NB];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .src_in(src_in), .grp_irq(grp_irq)
  );

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    int bk = int'(a[AW-1:4]);
    if (bk >= NB) return 32'h0;
    case (a[3:2])
      2'd0, 2'd1: return m_en[bk];
      2'd3:       return m_en[bk] & src_in[bk*32 +: 32];
      default:    return 32'h0;
    endcase
  endfunction

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R10: unexpected rd_valid, actual %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          mismatched++;
          $display("FAIL %s: read actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    int bk;
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    bk = int'(a[AW-1:4]);
    if (bk < NB) begin
      if (a[3:2] == 2'd0) m_en[bk] = m_en[bk] | d;
      if (a[3:2] == 2'd1) m_en[bk] = m_en[bk] & ~d;
    end
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, string t);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a;
    exp_q.push_back(model_read(a));
    tag_q.push_back(t);
    @(negedge clk);
    reg_en = 0;
  endtask

  task automatic check_irq(string t);
    logic [NG-1:0] e;
    for (int g = 0; g < NG; g++)
      e[g] = |(m_en[g/4][8*(g%4) +: 8] & src_in[8*g +: 8]);
    compared++;
    if (grp_irq !== e) begin
      mismatched++;
      $display("FAIL %s: grp_irq actual %h expected %h", t, grp_irq, e);
    end
  endtask

  task automatic check_bit(int g, logic v, string t);
    compared++;
    if (grp_irq[g] !== v) begin
      mismatched++;
      $display("FAIL %s: grp_irq[%0d] actual %b expected %b", t, g, grp_irq[g], v);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) m_en[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_irq("R1");
    for (int i = 0; i < NB; i++) rd(AW'(i * 16), "R1");

    // sources all high, nothing enabled
    src_in = '1;
    settle();
    check_irq("R1");

    // R2 set semantics and R4 read-back through both enable offsets
    wr(8'h00, 32'h0000_00A5);
    check_irq("R2");
    wr(8'h00, 32'h00FF_0000);
    rd(8'h00, "R2");
    rd(8'h04, "R4");
    // R3 clear semantics
    wr(8'h04, 32'h0000_0005);
    rd(8'h00, "R3");
    check_irq("R3");
    // R5 status with a mixed pattern
    src_in = '0;
    src_in[31:0] = 32'h1234_00F0;
    settle();
    rd(8'h0C, "R5");
    check_irq("R5");

    // R7 latency through the synchroniser on group 5 bit 3
    src_in = '0;
    wr(8'h10, 32'h0000_0800);
    settle();
    check_bit(5, 1'b0, "R7");
    @(negedge clk); src_in[5*8+3] = 1'b1;
    @(negedge clk); check_bit(5, 1'b0, "R7");
    @(negedge clk); check_bit(5, 1'b1, "R7");
    repeat (5) @(negedge clk);
    check_bit(5, 1'b1, "R6");
    src_in[5*8+3] = 1'b0;
    @(negedge clk); check_bit(5, 1'b1, "R7");
    @(negedge clk); check_bit(5, 1'b0, "R6");

    // R8 group 19 in bank at 0x40 lane 3
    wr(8'h40, 32'h8000_0000);
    src_in[159] = 1'b1;
    settle();
    check_irq("R8");
    check_bit(19, 1'b1, "R8");
    rd(8'h4C, "R8");

    // R9 ignored writes and zero reads
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h10, "R9");
    check_irq("R9");
    rd(8'h18, "R9");
    rd(8'h50, "R9");
    rd(8'h5C, "R9");

    // randomised patterns across all banks
    for (int k = 0; k < 12; k++) begin
      for (int b = 0; b < NB; b++) begin
        wr(AW'(b * 16 + 4), $urandom());
        wr(AW'(b * 16), $urandom());
      end
      for (int w = 0; w < NG * 8 / 32; w++) src_in[w*32 +: 32] = $urandom();
      settle();
      check_irq("R6");
      for (int b = 0; b < NB; b++) rd(AW'(b * 16 + 12), "R5");
      rd(AW'(($urandom() % NB) * 16 + 4), "R4");
    end

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R10: pending reads actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule